// File: doc/BRIEF.md
# Tributary Multiframe V1 Locator

This block sits on a byte-wide receive telecom bus that carries an STM-1 / VC-4 stream. Its inputs are the data byte, a one-cycle pulse that marks both the J0 and the J1 positions, a payload qualifier and a level enable for the multiframe. The multiframe enable rises after the path overhead byte that opens a new tributary multiframe. The block finds the V1 byte of the first tributary in the frame that starts each new multiframe. It gives a downstream tributary processor a one-cycle multiframe strobe at that byte, a J1 strobe and a payload strobe. The data byte passes through the same single register stage as these strobes, so each strobe leaves aligned with the byte it marks.

A rising edge of the multiframe enable arms the detector. The next J1 pulse starts a count of payload-qualified bytes, and the third such byte is taken as V1. Bytes outside the payload do not advance the count. A J0 pulse is told apart from J1 because it falls outside the payload.

A separate timing section runs on its own retiming clock. It counts one frame period of bus cycles to make a one-cycle 8 kHz frame pulse. It divides those pulses into a square 2 kHz multiframe clock.

Top module: `mfv1_locator`

## Requirements
- R1: While `rst_n` is sampled low, every output reads 0 from the next edge of its clock on, and all detection state is cleared. This includes an armed or counting detector, which does not fire after reset ends.
- R2: `trib_data` and `trib_pay` equal `bus_data` and `bus_pay` of the previous `clk` cycle.
- R3: `trib_j1` is 1 for one cycle after a `bus_j0j1` pulse that coincides with `bus_pay`=1 (J1). A `bus_j0j1` pulse with `bus_pay`=0 (J0) leaves `trib_j1` at 0.
- R4: After a 0-to-1 change of `bus_mfen`, the first later J1 starts a count. The third byte after that J1 with `bus_pay`=1 is V1, and `trib_mf` is 1 for one cycle exactly when `trib_data` carries that byte.
- R5: Bytes with `bus_pay`=0 between J1 and V1 are not counted.
- R6: No `trib_mf` appears without a new rising edge of `bus_mfen`. This holds for a J1 that arrives while the enable is held high or low, and for a J1 in the same cycle as the rising edge. An enable that is already high when reset ends counts as no edge.
- R7: `frm_8k` is a one-cycle pulse once every `FRAME_CYCLES` cycles of `ret_clk`.
- R8: `mf_2k` changes only in the cycle `frm_8k` is high, and only on every second frame pulse. It goes to 1 on the 2nd pulse after reset and back to 0 on the 4th, so its period is four frames with 50% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Telecom bus byte clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| bus_data | input | 8 | Incoming bus byte |
| bus_j0j1 | input | 1 | One-cycle pulse at J0 and at J1 |
| bus_pay | input | 1 | High on payload (VC-4) bytes |
| bus_mfen | input | 1 | Multiframe enable level; a rising edge marks a new multiframe |
| ret_clk | input | 1 | Retiming clock for the frame and multiframe references |
| trib_data | output | 8 | Bus byte delayed by one register stage |
| trib_j1 | output | 1 | J1 strobe aligned with `trib_data` |
| trib_pay | output | 1 | Payload strobe aligned with `trib_data` |
| trib_mf | output | 1 | Multiframe strobe at the V1 byte |
| frm_8k | output | 1 | One-cycle frame pulse in the `ret_clk` domain |
| mf_2k | output | 1 | Square multiframe clock in the `ret_clk` domain |

## Verification
The hardest case to reach from the ports is a detector that is armed, or already counting toward V1, at the moment reset arrives. Nothing at the outputs shows that state. The stimulus arms the detector with a rising enable, delivers J1 and one payload byte, then asserts reset. It releases reset with the enable still high and sends J1 and several payload bytes, so a stale arm or count would show up as a stray strobe. The table also places non-payload bytes inside the V1 count, and it makes the enable rise in the same cycle as a J1.

// File: rtl/mfv1_pkg.sv
`timescale 1ns/1ps
// Shared types for the V1 locator.
// Assumes: one strobe bundle per bus byte, produced and consumed in the clk domain.
package mfv1_pkg;

    // Per-byte timing strobes passed from detection to the output stage.
    typedef struct packed {
        logic j1;   // J1 occurrence (J0 excluded)
        logic pay;  // payload byte
        logic mf;   // V1 byte of a new tributary multiframe
    } strb_t;

endpackage

// File: rtl/mfv1_detect.sv
`timescale 1ns/1ps
// Finds the V1 byte that follows J1 in the frame after a rising multiframe enable.
// Assumes: a J1 pulse coincides with the payload qualifier and a J0 pulse does not.
module mfv1_detect #(
    parameter int V1_OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              j0j1,
    input  logic              pay,
    input  logic              mfen,
    output mfv1_pkg::strb_t   strb
);
    localparam int CW = (V1_OFFSET > 1) ? $clog2(V1_OFFSET) : 1;
    localparam logic [CW-1:0] LAST = CW'(V1_OFFSET - 1);

    logic          mfen_d;
    logic          armed;
    logic          counting;
    logic [CW-1:0] cnt;
    logic          rise;
    logic          j1_hit;
    logic          v1_hit;
    logic          start;

    assign rise   = mfen & ~mfen_d;
    assign j1_hit = j0j1 & pay;
    assign start  = armed & j1_hit & ~counting;
    assign v1_hit = counting & pay & (cnt == LAST);

    // Edge detection, arming and payload byte counting toward V1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfen_d   <= 1'b1;
            armed    <= 1'b0;
            counting <= 1'b0;
            cnt      <= '0;
        end else begin
            mfen_d <= mfen;
            if (rise)       armed <= 1'b1;
            else if (start) armed <= 1'b0;
            if (start) begin
                counting <= 1'b1;
                cnt      <= '0;
            end else if (counting && pay) begin
                if (v1_hit) counting <= 1'b0;
                else        cnt      <= cnt + 1'b1;
            end
        end
    end

    assign strb = '{j1: j1_hit, pay: pay, mf: v1_hit};

    // R6: counting only ever begins from the armed state.
    a_r6_count_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(counting) |-> $past(armed));

    // R1: reset clears arming and counting.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!armed && !counting));

endmodule

// File: rtl/mfv1_align.sv
`timescale 1ns/1ps
// Single register stage that keeps the data byte and its strobes in step.
// Assumes: the strobes describe the byte presented in the same cycle.
module mfv1_align #(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  din,
    input  mfv1_pkg::strb_t    sin,
    output logic [DATA_W-1:0]  dout,
    output mfv1_pkg::strb_t    sout
);
    // Register data and strobes together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            sout <= '0;
        end else begin
            dout <= din;
            sout <= sin;
        end
    end

    // R4: the multiframe strobe only marks payload bytes.
    a_r4_mf_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
        sout.mf |-> sout.pay);

    // R3: a J1 strobe only marks payload bytes.
    a_r3_j1_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
        sout.j1 |-> sout.pay);

endmodule

// File: rtl/mfv1_retime.sv
`timescale 1ns/1ps
// Frame pulse and square multiframe clock on the retiming clock.
// Assumes: MF_FRAMES is even; the clock runs at byte rate so FRAME_CYCLES spans a frame.
module mfv1_retime #(
    parameter int FRAME_CYCLES = 2430,
    parameter int MF_FRAMES    = 4
) (
    input  logic ret_clk,
    input  logic rst_n,
    output logic frm,
    output logic mf
);
    localparam int FW   = $clog2(FRAME_CYCLES);
    localparam int HALF = MF_FRAMES / 2;
    localparam logic [FW-1:0] FEND = FW'(FRAME_CYCLES - 1);

    logic [FW-1:0] fcnt;
    logic          wrap;

    assign wrap = (fcnt == FEND);

    // Frame period counter and registered frame pulse.
    always_ff @(posedge ret_clk) begin
        if (!rst_n) begin
            fcnt <= '0;
            frm  <= 1'b0;
        end else begin
            fcnt <= wrap ? '0 : fcnt + 1'b1;
            frm  <= wrap;
        end
    end

    generate
        if (HALF <= 1) begin : g_div_every
            // Toggle the multiframe clock on every frame.
            always_ff @(posedge ret_clk) begin
                if (!rst_n)    mf <= 1'b0;
                else if (wrap) mf <= ~mf;
            end
        end else begin : g_div_count
            localparam int HW = $clog2(HALF);
            localparam logic [HW-1:0] HEND = HW'(HALF - 1);
            logic [HW-1:0] hcnt;
            // Toggle the multiframe clock every HALF frames.
            always_ff @(posedge ret_clk) begin
                if (!rst_n) begin
                    hcnt <= '0;
                    mf   <= 1'b0;
                end else if (wrap) begin
                    if (hcnt == HEND) begin
                        hcnt <= '0;
                        mf   <= ~mf;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
            end
        end
    endgenerate

    // R7: the frame pulse lasts one cycle.
    a_r7_frame_single: assert property (@(posedge ret_clk) disable iff (!rst_n)
        frm |=> !frm);

    // R8: the multiframe clock moves only alongside a frame pulse.
    a_r8_mf_on_frame: assert property (@(posedge ret_clk) disable iff (!rst_n)
        (mf != $past(mf)) |-> frm);

endmodule

// File: rtl/mfv1_locator.sv
`timescale 1ns/1ps
// Top: V1 multiframe locator on a receive telecom bus plus retiming references.
// Assumes: rst_n is held low for several cycles of both clocks.
module mfv1_locator #(
    parameter int DATA_W       = 8,
    parameter int V1_OFFSET    = 3,
    parameter int FRAME_CYCLES = 2430,
    parameter int MF_FRAMES    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_j0j1,
    input  logic              bus_pay,
    input  logic              bus_mfen,
    input  logic              ret_clk,
    output logic [DATA_W-1:0] trib_data,
    output logic              trib_j1,
    output logic              trib_pay,
    output logic              trib_mf,
    output logic              frm_8k,
    output logic              mf_2k
);
    mfv1_pkg::strb_t strb_in;
    mfv1_pkg::strb_t strb_out;

    mfv1_detect #(.V1_OFFSET(V1_OFFSET)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .j0j1  (bus_j0j1),
        .pay   (bus_pay),
        .mfen  (bus_mfen),
        .strb  (strb_in)
    );

    mfv1_align #(.DATA_W(DATA_W)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_data),
        .sin   (strb_in),
        .dout  (trib_data),
        .sout  (strb_out)
    );

    mfv1_retime #(.FRAME_CYCLES(FRAME_CYCLES), .MF_FRAMES(MF_FRAMES)) u_retime (
        .ret_clk (ret_clk),
        .rst_n   (rst_n),
        .frm     (frm_8k),
        .mf      (mf_2k)
    );

    assign trib_j1  = strb_out.j1;
    assign trib_pay = strb_out.pay;
    assign trib_mf  = strb_out.mf;

    // R4: one multiframe strobe per V1, never back to back.
    a_r4_mf_single: assert property (@(posedge clk) disable iff (!rst_n)
        trib_mf |=> !trib_mf);

    // R1: reset drives the bus-side strobes low.
    a_r1_strobes_low: assert property (@(posedge clk)
        !rst_n |=> (!trib_mf && !trib_j1 && !trib_pay));

endmodule

// File: tb/test_mfv1_locator.sv
`timescale 1ns/1ps
module test_mfv1_locator;

    localparam int N = 2430;

    logic       clk = 1'b0;
    logic       ret_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_data = '0;
    logic       bus_j0j1 = 1'b0;
    logic       bus_pay = 1'b0;
    logic       bus_mfen = 1'b0;
    logic [7:0] trib_data;
    logic       trib_j1, trib_pay, trib_mf, frm_8k, mf_2k;

    int  nchk = 0;
    int  nerr = 0;
    bit  ret_done = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;
    always #25.7 ret_clk = ~ret_clk;

    mfv1_locator i_mfv1_locator (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_j0j1(bus_j0j1),
        .bus_pay(bus_pay), .bus_mfen(bus_mfen), .ret_clk(ret_clk),
        .trib_data(trib_data), .trib_j1(trib_j1), .trib_pay(trib_pay),
        .trib_mf(trib_mf), .frm_8k(frm_8k), .mf_2k(mf_2k)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       j;
        logic       p;
        logic       m;
        logic       ej;
        logic       emf;
        logic [3:0] req;
    } vec_t;

    // Expected trib_* after the edge at which the row is applied; data/pay echo inputs (R2).
    localparam vec_t VEC [35] = '{
        '{8'hA0,0,0,0,0,0,6}, '{8'h11,1,0,0,0,0,3},  // J0 gives no J1 strobe (R3)
        '{8'h22,0,0,0,0,0,6}, '{8'h33,1,1,0,1,0,6},  // J1 while not armed (R6)
        '{8'h44,0,1,0,0,0,6}, '{8'h55,0,1,0,0,0,6},
        '{8'h66,0,1,0,0,0,6}, '{8'h77,0,1,1,0,0,6},  // enable rises: arm
        '{8'h88,0,1,1,0,0,6}, '{8'h99,1,0,1,0,0,3},  // J0 of next frame
        '{8'h9A,1,1,1,1,0,4}, '{8'hAB,0,0,1,0,0,5},  // J1 starts count; gap not counted (R5)
        '{8'hBC,0,1,1,0,0,5}, '{8'hCD,0,1,1,0,0,5},
        '{8'hDE,0,0,1,0,0,5}, '{8'hEF,0,1,1,0,1,4},  // third payload byte is V1 (R4)
        '{8'hF0,0,1,1,0,0,4}, '{8'h01,1,1,1,1,0,6},  // J1 with enable held high (R6)
        '{8'h02,0,1,1,0,0,6}, '{8'h03,0,1,1,0,0,6},
        '{8'h04,0,1,1,0,0,6}, '{8'h05,0,1,0,0,0,6},
        '{8'h06,1,1,0,1,0,6}, '{8'h07,0,1,0,0,0,6},  // J1 with enable low (R6)
        '{8'h08,0,1,0,0,0,6}, '{8'h09,0,1,0,0,0,6},
        '{8'h10,1,1,1,1,0,6}, '{8'h11,0,1,1,0,0,6},  // rise in same cycle as J1 (R6)
        '{8'h12,0,1,1,0,0,6}, '{8'h13,0,1,1,0,0,6},
        '{8'h14,1,1,1,1,0,4}, '{8'h15,0,1,1,0,0,4},  // next J1 starts count
        '{8'h16,0,1,1,0,0,4}, '{8'h17,0,1,1,0,1,4},  // V1 (R4)
        '{8'h18,0,1,1,0,0,4}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] d, input logic j, input logic p, input logic m);
        bus_data = d; bus_j0j1 = j; bus_pay = p; bus_mfen = m;
    endtask

    task automatic step_check(input logic [7:0] d, input logic j, input logic p, input logic m,
                              input logic ej, input logic emf, input string mreq);
        drive(d, j, p, m);
        @(negedge clk);
        chk(trib_data == d, "R2 data", trib_data, d);
        chk(trib_pay == p, "R2 pay", trib_pay, p);
        chk(trib_j1 == ej, "R3 j1", trib_j1, ej);
        chk(trib_mf == emf, mreq, trib_mf, emf);
    endtask

    // Retiming domain monitor: R7 period and width, R8 multiframe pattern.
    initial begin
        int  cyc = 0;
        int  last = -1;
        int  np = 0;
        bit  prev = 1'b0;
        bit  r8_bad = 1'b0;
        logic mf_hold = 1'b0;
        wait (rst_n === 1'b1);
        while (np < 5) begin
            @(negedge ret_clk);
            cyc++;
            if (frm_8k) begin
                np++;
                chk(!prev, "R7 width", prev, 0);
                if (last >= 0) chk(cyc - last == N, "R7 period", cyc - last, N);
                chk(mf_2k == (((np / 2) % 2) == 1), "R8 level", mf_2k, ((np / 2) % 2));
                mf_hold = mf_2k;
                last = cyc;
            end else if (np > 0 && mf_2k != mf_hold) begin
                r8_bad = 1'b1;
            end
            prev = frm_8k;
        end
        chk(!r8_bad, "R8 stable between pulses", r8_bad, 0);
        ret_done = 1'b1;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        drive(8'h5A, 1'b0, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk(trib_data == 8'h00, "R1 data", trib_data, 0);
        chk({trib_j1, trib_pay, trib_mf} == 3'b000, "R1 strobes", {trib_j1, trib_pay, trib_mf}, 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 35; i++) begin
            step_check(VEC[i].d, VEC[i].j, VEC[i].p, VEC[i].m, VEC[i].ej, VEC[i].emf,
                       $sformatf("R%0d mf row %0d", VEC[i].req, i));
        end

        wait (ret_done);
        @(negedge clk);

        // R1: reset while armed and counting
        step_check(8'h20, 0, 1, 0, 0, 0, "R6 mf");
        step_check(8'h21, 0, 1, 1, 0, 0, "R6 mf");
        step_check(8'h22, 1, 1, 1, 1, 0, "R4 mf");
        step_check(8'h23, 0, 1, 1, 0, 0, "R4 mf");
        drive(8'h5A, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk({trib_j1, trib_pay, trib_mf} == 3'b000, "R1 strobes mid-count", {trib_j1, trib_pay, trib_mf}, 0);
        chk(trib_data == 8'h00, "R1 data mid-count", trib_data, 0);
        @(negedge ret_clk);
        @(negedge ret_clk);
        chk({frm_8k, mf_2k} == 2'b00, "R1 retime outputs", {frm_8k, mf_2k}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R6: no stale arm; enable already high at reset exit is no edge
        step_check(8'h30, 1, 1, 1, 1, 0, "R1 mf after reset");
        step_check(8'h31, 0, 1, 1, 0, 0, "R1 mf after reset");
        step_check(8'h32, 0, 1, 1, 0, 0, "R6 mf after reset");
        step_check(8'h33, 0, 1, 1, 0, 0, "R6 mf after reset");
        step_check(8'h34, 0, 1, 1, 0, 0, "R6 mf after reset");

        // R4: fresh edge after reset still locates V1
        step_check(8'h40, 0, 0, 0, 0, 0, "R4 mf");
        step_check(8'h41, 0, 0, 1, 0, 0, "R4 mf");
        step_check(8'h42, 1, 1, 1, 1, 0, "R4 mf");
        step_check(8'h43, 0, 1, 1, 0, 0, "R4 mf");
        step_check(8'h44, 0, 1, 1, 0, 0, "R4 mf");
        step_check(8'h45, 0, 1, 1, 0, 1, "R4 mf at V1");
        step_check(8'h46, 0, 1, 1, 0, 0, "R4 mf");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule